// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block is the front end of a parallel NOR flash model. It watches the chip-enable, write-enable and output-enable strobes, sampled on a system clock, and turns them into discrete bus writes. It then follows the multi-write command sequences that select program, block erase, chip erase, identify and reset. When a program or erase sequence completes while the high programming supply is present, it sends a one-cycle start request to an operation engine. The request carries the operation kind, the full target address and the full data word.

The decoder reports a bus mode: array read, identify, or status. In identify mode it returns the manufacturer and device codes for the word address being read. In status mode the engine is running, or has ended in failure. The engine drives a busy flag from the cycle after the start request until it finishes, and reports failure alongside it. The timing of the array itself and the formatting of the status bits belong to other blocks.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A bus write happens when the sampled `ce_ni` and `we_ni` go from both-low to not-both-low. The address is taken from the first sample with both low. The data is taken from the last sample with both low. If `oe_ni` is low in any sample with both low, the write is discarded and has no effect on the sequence.
- R2: Commands are decoded only from address bits 10:0 and data bits 7:0, and the upper bits are don't-care. The unlock pair is data AAh at address 555h followed by data 55h at address 2AAh.
- R3: After reset, `mode_o` is 00 (array read) and no start is issued. Any write that does not continue a valid sequence returns the decoder to the start of the array-read sequence without a start request.
- R4: A write of data F0h at any address is a reset when the decoder is not running an operation and not waiting for the program data word. This covers a lone F0h as well as F0h after an unlock pair. A reset sets `mode_o` to 00 and pulses `clr_err_o` for one cycle.
- R5: Unlock plus 90h at 555h enters identify mode (`mode_o` = 01). Identify mode stays until a reset, and no other write has any effect in it. In identify mode, `id_o` is 0020h for address bits 1:0 = 00, 88AFh for 01, and 0 for other values. Outside identify mode, `id_o` is 0.
- R6: Unlock plus A0h at 555h, followed by any fourth write, requests a word program. This raises `start_o` with `op_kind_o` = 01, and with `op_addr_o`/`op_data_o` equal to the full address and data of the fourth write.
- R7: Unlock, 80h at 555h, and a second unlock, followed by 30h at any address, requests a block erase: `op_kind_o` = 10, `op_addr_o` = the write's full address, `op_data_o` = 0. If the sixth write is 10h at 555h instead, the request is a chip erase: `op_kind_o` = 11, address 0 and data 0.
- R8: If `vpp_hi_i` is low at the final write of a program or erase sequence, no start is issued and the decoder returns to array read. Identify and reset are not affected by `vpp_hi_i`.
- R9: `start_o` lasts exactly one cycle and switches `mode_o` to 10 (status). While the engine runs, every write is ignored, including F0h. When `busy_i` falls, the decoder returns to 00 if `fail_i` is low. If `fail_i` is high, it stays at 10 and ignores everything except a reset. `busy_i` must be high from the cycle after `start_o`.
- R10: `start_o` and `clr_err_o` rise in the clock cycle after the edge at which the strobes are first sampled as released. When `start_o` is low, `op_kind_o`, `op_addr_o` and `op_data_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_ni | input | 1 | Chip enable, active low |
| we_ni | input | 1 | Write enable, active low |
| oe_ni | input | 1 | Output enable, active low |
| addr_i | input | ADDR_W | Bus address |
| data_i | input | DATA_W | Bus write data |
| vpp_hi_i | input | 1 | High programming supply present |
| busy_i | input | 1 | Operation engine running |
| fail_i | input | 1 | Operation engine ended in failure |
| start_o | output | 1 | One-cycle operation request |
| op_kind_o | output | 2 | 01 program, 10 block erase, 11 chip erase |
| op_addr_o | output | ADDR_W | Operation address |
| op_data_o | output | DATA_W | Program data |
| clr_err_o | output | 1 | Pulse on an accepted reset command |
| mode_o | output | 2 | 00 array, 01 identify, 10 status |
| id_o | output | DATA_W | Identification code in identify mode |

## Verification
Several properties are checked on every cycle. A start request lasts one cycle. It only comes from array mode, only with the supply high, and always moves the bus to status. The operand fields stay zero without a start, and a chip erase always carries address zero. Identification codes appear only in identify mode, and a clear pulse always leaves the decoder in array mode. Other behaviour needs whole write sequences and only the bench scenarios can show it. This covers the order in which address and data are captured under write-enable-controlled and chip-enable-controlled timing, and writes discarded because output-enable was low. It also covers the stickiness of identify and failure modes, writes ignored while busy, and the upper address and data bits being don't-care.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int KEY_AW = 11;
  localparam int KEY_DW = 8;

  localparam logic [KEY_AW-1:0] ADR_KEY1  = 11'h555;
  localparam logic [KEY_AW-1:0] ADR_KEY2  = 11'h2AA;
  localparam logic [KEY_DW-1:0] DAT_KEY1  = 8'hAA;
  localparam logic [KEY_DW-1:0] DAT_KEY2  = 8'h55;
  localparam logic [KEY_DW-1:0] CMD_IDENT = 8'h90;
  localparam logic [KEY_DW-1:0] CMD_PGM   = 8'hA0;
  localparam logic [KEY_DW-1:0] CMD_ERASE = 8'h80;
  localparam logic [KEY_DW-1:0] CMD_BLOCK = 8'h30;
  localparam logic [KEY_DW-1:0] CMD_CHIP  = 8'h10;
  localparam logic [KEY_DW-1:0] CMD_RESET = 8'hF0;

  typedef enum logic [3:0] {
    ST_IDLE, ST_UNL1, ST_UNL2, ST_PGM,
    ST_ERS1, ST_ERS2, ST_ERS3,
    ST_ASEL, ST_ASEL1, ST_ASEL2,
    ST_BUSY, ST_FAIL, ST_FAIL1, ST_FAIL2
  } cmd_state_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_PGM  = 2'b01,
    OP_BLK  = 2'b10,
    OP_CHIP = 2'b11
  } op_kind_e;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'b00,
    MODE_IDENT  = 2'b01,
    MODE_STATUS = 2'b10
  } bus_mode_e;

endpackage

// File: rtl/flash_wr_capture.sv
module flash_wr_capture #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              wr_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);

  logic              act, act_q, oe_bad_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;

  assign act = ~ce_ni & ~we_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q    <= 1'b0;
      oe_bad_q <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
    end else begin
      act_q <= act;
      // later falling edge of the pair opens the write
      if (act && !act_q) begin
        addr_q   <= addr_i;
        oe_bad_q <= ~oe_ni;
      end else if (act && !oe_ni) begin
        oe_bad_q <= 1'b1;
      end
      // keep the last active sample: earlier rising edge closes the write
      if (act) data_q <= data_i;
    end
  end

  assign wr_o      = act_q & ~act & ~oe_bad_q;
  assign wr_addr_o = addr_q;
  assign wr_data_o = data_q;

endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              vpp_hi_i,
  input  logic              busy_i,
  input  logic              fail_i,
  output logic              start_o,
  output logic [1:0]        op_kind_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic              clr_err_o,
  output logic [1:0]        mode_o
);

  cmd_state_e        state_q, state_d;
  op_kind_e          kind_q, kind_d;
  logic              start_q, start_d, clr_q, clr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  bus_mode_e         mode;

  logic [KEY_AW-1:0] a_lo;
  logic [KEY_DW-1:0] d_lo;
  logic              hit_k1, hit_k2, at_key1, rst_ok;

  assign a_lo    = wr_addr_i[KEY_AW-1:0];
  assign d_lo    = wr_data_i[KEY_DW-1:0];
  assign at_key1 = (a_lo == ADR_KEY1);
  assign hit_k1  = at_key1 && (d_lo == DAT_KEY1);
  assign hit_k2  = (a_lo == ADR_KEY2) && (d_lo == DAT_KEY2);
  // reset is honoured everywhere except the data slot and a running op
  assign rst_ok  = wr_i && (d_lo == CMD_RESET) &&
                   (state_q != ST_PGM) && (state_q != ST_BUSY);

  always_comb begin
    state_d = state_q;
    start_d = 1'b0;
    kind_d  = OP_NONE;
    addr_d  = '0;
    data_d  = '0;
    clr_d   = 1'b0;
    if (rst_ok) begin
      state_d = ST_IDLE;
      clr_d   = 1'b1;
    end else begin
      case (state_q)
        ST_IDLE:  if (wr_i && hit_k1) state_d = ST_UNL1;
        ST_UNL1:  if (wr_i) state_d = hit_k2 ? ST_UNL2 : ST_IDLE;
        ST_UNL2: begin
          if (wr_i) begin
            state_d = ST_IDLE;
            if (at_key1) begin
              case (d_lo)
                CMD_IDENT: state_d = ST_ASEL;
                CMD_PGM:   state_d = ST_PGM;
                CMD_ERASE: state_d = ST_ERS1;
                default:   state_d = ST_IDLE;
              endcase
            end
          end
        end
        ST_PGM: begin
          if (wr_i) begin
            state_d = ST_IDLE;
            if (vpp_hi_i) begin
              state_d = ST_BUSY;
              start_d = 1'b1;
              kind_d  = OP_PGM;
              addr_d  = wr_addr_i;
              data_d  = wr_data_i;
            end
          end
        end
        ST_ERS1:  if (wr_i) state_d = hit_k1 ? ST_ERS2 : ST_IDLE;
        ST_ERS2:  if (wr_i) state_d = hit_k2 ? ST_ERS3 : ST_IDLE;
        ST_ERS3: begin
          if (wr_i) begin
            state_d = ST_IDLE;
            if (vpp_hi_i && d_lo == CMD_BLOCK) begin
              state_d = ST_BUSY;
              start_d = 1'b1;
              kind_d  = OP_BLK;
              addr_d  = wr_addr_i;
            end else if (vpp_hi_i && at_key1 && d_lo == CMD_CHIP) begin
              state_d = ST_BUSY;
              start_d = 1'b1;
              kind_d  = OP_CHIP;
            end
          end
        end
        ST_ASEL:  if (wr_i && hit_k1) state_d = ST_ASEL1;
        ST_ASEL1: if (wr_i) state_d = hit_k2 ? ST_ASEL2 : ST_ASEL;
        ST_ASEL2: if (wr_i) state_d = ST_ASEL;
        ST_BUSY:  if (!busy_i) state_d = fail_i ? ST_FAIL : ST_IDLE;
        ST_FAIL:  if (wr_i && hit_k1) state_d = ST_FAIL1;
        ST_FAIL1: if (wr_i) state_d = hit_k2 ? ST_FAIL2 : ST_FAIL;
        ST_FAIL2: if (wr_i) state_d = ST_FAIL;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_ASEL, ST_ASEL1, ST_ASEL2:          mode = MODE_IDENT;
      ST_BUSY, ST_FAIL, ST_FAIL1, ST_FAIL2: mode = MODE_STATUS;
      default:                              mode = MODE_ARRAY;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      start_q <= 1'b0;
      kind_q  <= OP_NONE;
      addr_q  <= '0;
      data_q  <= '0;
      clr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      kind_q  <= kind_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      clr_q   <= clr_d;
    end
  end

  assign start_o   = start_q;
  assign op_kind_o = kind_q;
  assign op_addr_o = addr_q;
  assign op_data_o = data_q;
  assign clr_err_o = clr_q;
  assign mode_o    = mode;

endmodule

// File: rtl/flash_id_mux.sv
module flash_id_mux #(
  parameter int               DATA_W   = 16,
  parameter logic [DATA_W-1:0] MFR_CODE = 'h0020,
  parameter logic [DATA_W-1:0] DEV_CODE = 'h88AF
) (
  input  logic              ident_i,
  input  logic [1:0]        sel_i,
  output logic [DATA_W-1:0] id_o
);

  always_comb begin
    id_o = '0;
    if (ident_i) begin
      case (sel_i)
        2'b00:   id_o = MFR_CODE;
        2'b01:   id_o = DEV_CODE;
        default: id_o = '0;
      endcase
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int               ADDR_W   = 22,
  parameter int               DATA_W   = 16,
  parameter logic [DATA_W-1:0] MFR_CODE = 'h0020,
  parameter logic [DATA_W-1:0] DEV_CODE = 'h88AF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              we_ni,
  input  logic              oe_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              vpp_hi_i,
  input  logic              busy_i,
  input  logic              fail_i,
  output logic              start_o,
  output logic [1:0]        op_kind_o,
  output logic [ADDR_W-1:0] op_addr_o,
  output logic [DATA_W-1:0] op_data_o,
  output logic              clr_err_o,
  output logic [1:0]        mode_o,
  output logic [DATA_W-1:0] id_o
);

  logic              wr_evt;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [1:0]        mode;

  flash_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ce_ni     (ce_ni),
    .we_ni     (we_ni),
    .oe_ni     (oe_ni),
    .addr_i    (addr_i),
    .data_i    (data_i),
    .wr_o      (wr_evt),
    .wr_addr_o (wr_addr),
    .wr_data_o (wr_data)
  );

  flash_cmd_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_evt),
    .wr_addr_i (wr_addr),
    .wr_data_i (wr_data),
    .vpp_hi_i  (vpp_hi_i),
    .busy_i    (busy_i),
    .fail_i    (fail_i),
    .start_o   (start_o),
    .op_kind_o (op_kind_o),
    .op_addr_o (op_addr_o),
    .op_data_o (op_data_o),
    .clr_err_o (clr_err_o),
    .mode_o    (mode)
  );

  flash_id_mux #(.DATA_W(DATA_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE)) u_id (
    .ident_i (mode == MODE_IDENT),
    .sel_i   (addr_i[1:0]),
    .id_o    (id_o)
  );

  assign mode_o = mode;

endmodule

// File: rtl/flash_cmd_decoder_chk.sv
module flash_cmd_decoder_chk #(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              vpp_hi_i,
  input logic              start_o,
  input logic [1:0]        op_kind_o,
  input logic [ADDR_W-1:0] op_addr_o,
  input logic [DATA_W-1:0] op_data_o,
  input logic              clr_err_o,
  input logic [1:0]        mode_o,
  input logic [DATA_W-1:0] id_o
);

  p_start_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |=> !start_o);

  p_start_needs_vpp_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(vpp_hi_i));

  p_start_from_array_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(mode_o) == 2'b00);

  p_start_status_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> mode_o == 2'b10);

  p_kind_valid_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> op_kind_o != 2'b00);

  p_fields_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_o |-> (op_kind_o == 2'b00 && op_addr_o == '0 && op_data_o == '0));

  p_chip_addr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_o && op_kind_o == 2'b11) |-> (op_addr_o == '0 && op_data_o == '0));

  p_id_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'b01 |-> id_o == '0);

  p_clr_to_array_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_err_o |-> (!start_o && mode_o == 2'b00));

  p_mode_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o != 2'b11);

endmodule

bind flash_cmd_decoder flash_cmd_decoder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .vpp_hi_i  (vpp_hi_i),
  .start_o   (start_o),
  .op_kind_o (op_kind_o),
  .op_addr_o (op_addr_o),
  .op_data_o (op_data_o),
  .clr_err_o (clr_err_o),
  .mode_o    (mode_o),
  .id_o      (id_o)
);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        ce_ni = 1'b1, we_ni = 1'b1, oe_ni = 1'b1;
  logic [21:0] addr_i = '0;
  logic [15:0] data_i = '0;
  logic        vpp_hi_i = 1'b1;
  logic        busy_i = 1'b0, fail_i = 1'b0;
  logic        start_o, clr_err_o;
  logic [1:0]  op_kind_o, mode_o;
  logic [21:0] op_addr_o;
  logic [15:0] op_data_o, id_o;

  flash_cmd_decoder uut (
    .clk_i(clk), .rst_ni(rst_ni), .ce_ni(ce_ni), .we_ni(we_ni), .oe_ni(oe_ni),
    .addr_i(addr_i), .data_i(data_i), .vpp_hi_i(vpp_hi_i), .busy_i(busy_i),
    .fail_i(fail_i), .start_o(start_o), .op_kind_o(op_kind_o),
    .op_addr_o(op_addr_o), .op_data_o(op_data_o), .clr_err_o(clr_err_o),
    .mode_o(mode_o), .id_o(id_o)
  );

  always #4 clk = ~clk;

  int    n_chk = 0, n_err = 0;
  string cur_req = "R3";
  bit    done = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- reference model: write log interpreted by pattern
  int          cat = 0;          // 0 array, 1 identify, 2 running, 3 failed
  logic [18:0] seq[$];
  logic        m_act_q = 1'b0, m_bad = 1'b0, m_act, m_commit;
  logic [21:0] m_addr = '0;
  logic [15:0] m_data = '0;
  logic        e_start = 1'b0, e_clr = 1'b0;
  logic [1:0]  e_kind = '0;
  logic [21:0] e_addr = '0;
  logic [15:0] e_data = '0;

  function automatic logic [18:0] key_at(input int n);
    return (n == 2 || n == 5) ? {11'h2AA, 8'h55} : {11'h555, 8'hAA};
  endfunction

  task automatic model_write(input logic [21:0] wa, input logic [15:0] wd);
    logic [10:0] a;
    logic [7:0]  d;
    int          n;
    bit          ok;
    a = wa[10:0];
    d = wd[7:0];
    if (cat == 0) begin
      if (seq.size() == 3 && seq[2] == {11'h555, 8'hA0}) begin
        seq.delete();
        if (vpp_hi_i) begin
          e_start = 1; e_kind = 2'b01; e_addr = wa; e_data = wd; cat = 2;
        end
      end else if (d == 8'hF0) begin
        seq.delete(); e_clr = 1;
      end else begin
        seq.push_back({a, d});
        n = seq.size();
        ok = 0;
        if (n == 1 || n == 2 || n == 4 || n == 5) ok = (seq[n-1] == key_at(n));
        else if (n == 3) begin
          ok = (a == 11'h555) && (d == 8'hA0 || d == 8'h80);
          if (a == 11'h555 && d == 8'h90) begin cat = 1; ok = 0; end
        end else if (n == 6) begin
          if (vpp_hi_i && d == 8'h30) begin
            e_start = 1; e_kind = 2'b10; e_addr = wa; cat = 2;
          end else if (vpp_hi_i && a == 11'h555 && d == 8'h10) begin
            e_start = 1; e_kind = 2'b11; cat = 2;
          end
        end
        if (!ok) seq.delete();
      end
    end else begin
      if (d == 8'hF0) begin
        seq.delete(); e_clr = 1; cat = 0;
      end else begin
        seq.push_back({a, d});
        n = seq.size();
        if (!((n == 1 || n == 2) && seq[n-1] == key_at(n))) seq.delete();
      end
    end
  endtask

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cat = 0; seq.delete(); m_act_q = 0; m_bad = 0; m_addr = '0; m_data = '0;
      e_start = 0; e_clr = 0; e_kind = '0; e_addr = '0; e_data = '0;
    end else begin
      e_start = 0; e_clr = 0; e_kind = '0; e_addr = '0; e_data = '0;
      m_act    = !ce_ni && !we_ni;
      m_commit = m_act_q && !m_act && !m_bad;
      if (cat == 2) begin
        if (!busy_i) cat = fail_i ? 3 : 0;
      end else if (m_commit) begin
        model_write(m_addr, m_data);
      end
      if (m_act && !m_act_q) begin m_addr = addr_i; m_bad = !oe_ni; end
      else if (m_act && !oe_ni) m_bad = 1;
      if (m_act) m_data = data_i;
      m_act_q = m_act;
    end
  end

  // ---------------- per-cycle comparison
  logic [1:0]  x_mode;
  logic [15:0] x_id;
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      x_mode = (cat == 1) ? 2'b01 : (cat >= 2) ? 2'b10 : 2'b00;
      x_id   = 16'h0;
      if (cat == 1) x_id = (addr_i[1:0] == 2'b00) ? 16'h0020 :
                           (addr_i[1:0] == 2'b01) ? 16'h88AF : 16'h0;
      n_chk++;
      if ({start_o, op_kind_o, op_addr_o, op_data_o, clr_err_o, mode_o, id_o} !==
          {e_start, e_kind, e_addr, e_data, e_clr, x_mode, x_id}) begin
        n_err++;
        $display("FAIL %s cycle: got st=%b k=%b a=%h d=%h clr=%b m=%b id=%h expected st=%b k=%b a=%h d=%h clr=%b m=%b id=%h",
                 cur_req, start_o, op_kind_o, op_addr_o, op_data_o, clr_err_o, mode_o, id_o,
                 e_start, e_kind, e_addr, e_data, e_clr, x_mode, x_id);
      end
    end
  end

  // ---------------- operation engine and observers
  int          busy_len = 4, busy_cnt = 0, n_start = 0, n_clr = 0;
  bit          fail_plan = 0;
  logic [1:0]  last_kind = '0;
  logic [21:0] last_addr = '0;
  logic [15:0] last_data = '0;
  always @(negedge clk) begin
    if (start_o) begin
      n_start++; last_kind = op_kind_o; last_addr = op_addr_o; last_data = op_data_o;
      busy_i = 1; fail_i = 0; busy_cnt = busy_len;
    end else if (busy_cnt > 0) begin
      busy_cnt--;
      if (busy_cnt == 0) begin busy_i = 0; fail_i = fail_plan; end
    end
    if (clr_err_o) n_clr++;
  end

  // ---------------- bus tasks
  task automatic wr(input logic [21:0] a, input logic [15:0] d);
    @(negedge clk); addr_i = a; data_i = d;
    @(negedge clk); ce_ni = 0; we_ni = 0;
    repeat (2) @(negedge clk);
    we_ni = 1; ce_ni = 1; data_i = ~d; addr_i = ~a;
    @(negedge clk);
  endtask

  task automatic wr_ce(input logic [21:0] a_early, input logic [21:0] a, input logic [15:0] d);
    @(negedge clk); addr_i = a_early; data_i = d; we_ni = 0;
    @(negedge clk); addr_i = a; ce_ni = 0;
    @(negedge clk); ce_ni = 1; data_i = ~d;
    @(negedge clk); we_ni = 1;
    @(negedge clk);
  endtask

  task automatic wr_oe_low(input logic [21:0] a, input logic [15:0] d);
    @(negedge clk); addr_i = a; data_i = d;
    @(negedge clk); ce_ni = 0; we_ni = 0;
    @(negedge clk); oe_ni = 0;
    @(negedge clk); oe_ni = 1;
    we_ni = 1; ce_ni = 1;
    @(negedge clk);
  endtask

  task automatic unlock();
    wr(22'h000555, 16'h00AA);
    wr(22'h0002AA, 16'h0055);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL R9 watchdog: got timeout expected completion");
      $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  // ---------------- scenarios
  int clr0;
  initial begin
    settle(3);
    rst_ni = 1;
    chk("R3 reset mode", {30'b0, mode_o}, 32'h0);
    chk("R3 reset start", {31'b0, start_o}, 32'h0);

    // R6 / R10 program, R9 success return
    cur_req = "R6 R10";
    unlock(); wr(22'h000555, 16'h00A0); wr(22'h012345, 16'hBEEF);
    settle(10);
    chk("R6 start count", n_start, 1);
    chk("R6 kind", {30'b0, last_kind}, 32'h1);
    chk("R6 addr", {10'b0, last_addr}, 32'h012345);
    chk("R6 data", {16'b0, last_data}, 32'hBEEF);
    chk("R9 back to array", {30'b0, mode_o}, 32'h0);

    // R2 upper bits are don't-care
    cur_req = "R2";
    wr(22'h3FF555, 16'h12AA); wr(22'h01A2AA, 16'hFF55); wr(22'h2AA555, 16'h77A0);
    wr(22'h000777, 16'h1234);
    settle(10);
    chk("R2 start count", n_start, 2);

    // R3 broken sequence
    cur_req = "R3";
    wr(22'h000555, 16'h00AA); wr(22'h0002AA, 16'h0056);
    wr(22'h000555, 16'h00A0); wr(22'h000100, 16'h0000);
    settle(4);
    chk("R3 no start", n_start, 2);
    chk("R3 array mode", {30'b0, mode_o}, 32'h0);

    // R1 chip-enable-controlled capture and discarded write
    cur_req = "R1";
    wr_ce(22'h000000, 22'h000555, 16'h00AA);
    wr(22'h0002AA, 16'h0055);
    wr_oe_low(22'h000555, 16'h0080);
    wr(22'h000555, 16'h00A0);
    wr_ce(22'h033333, 22'h00ABCD, 16'h5A5A);
    settle(10);
    chk("R1 start count", n_start, 3);
    chk("R1 late address", {10'b0, last_addr}, 32'h00ABCD);
    chk("R1 early data", {16'b0, last_data}, 32'h5A5A);

    // R7 block erase failing, R9 writes ignored while busy, R4 three-write reset
    cur_req = "R7 R9";
    busy_len = 30; fail_plan = 1;
    clr0 = n_clr;
    unlock(); wr(22'h000555, 16'h0080); unlock(); wr(22'h150000, 16'h0030);
    wr(22'h000000, 16'h00F0);
    chk("R9 reset ignored while busy", n_clr, clr0);
    chk("R9 status while busy", {30'b0, mode_o}, 32'h2);
    settle(30);
    chk("R7 block start", n_start, 4);
    chk("R7 block kind", {30'b0, last_kind}, 32'h2);
    chk("R7 block addr", {10'b0, last_addr}, 32'h150000);
    chk("R9 failure holds status", {30'b0, mode_o}, 32'h2);
    wr(22'h000555, 16'h00A0);
    chk("R9 failure ignores command", {30'b0, mode_o}, 32'h2);
    cur_req = "R4";
    unlock(); wr(22'h000123, 16'h00F0);
    settle(2);
    chk("R4 clear pulse", n_clr, clr0 + 1);
    chk("R4 array after reset", {30'b0, mode_o}, 32'h0);
    fail_plan = 0; busy_len = 4;

    // R8 supply low
    cur_req = "R8";
    vpp_hi_i = 0;
    unlock(); wr(22'h000555, 16'h0080); unlock(); wr(22'h000555, 16'h0010);
    settle(4);
    chk("R8 no start", n_start, 4);
    chk("R8 array", {30'b0, mode_o}, 32'h0);
    unlock(); wr(22'h000555, 16'h0090);
    chk("R8 identify at low supply", {30'b0, mode_o}, 32'h1);
    vpp_hi_i = 1;

    // R5 identify codes and stickiness
    cur_req = "R5";
    @(negedge clk); addr_i = 22'h3F0000; #1;
    chk("R5 maker code", {16'b0, id_o}, 32'h0020);
    @(negedge clk); addr_i = 22'h000001; #1;
    chk("R5 device code", {16'b0, id_o}, 32'h88AF);
    @(negedge clk); addr_i = 22'h000002; #1;
    chk("R5 other address", {16'b0, id_o}, 32'h0);
    unlock(); wr(22'h000555, 16'h00A0); wr(22'h000040, 16'h0001);
    unlock(); wr(22'h000555, 16'h0090);
    settle(4);
    chk("R5 program ignored", n_start, 4);
    chk("R5 stays identify", {30'b0, mode_o}, 32'h1);
    cur_req = "R4";
    clr0 = n_clr;
    wr(22'h000000, 16'h00F0);
    settle(2);
    chk("R4 single-write reset", n_clr, clr0 + 1);
    chk("R5 identify left", {30'b0, mode_o}, 32'h0);

    // R7 chip erase
    cur_req = "R7";
    unlock(); wr(22'h000555, 16'h0080); unlock(); wr(22'h3FF555, 16'hAB10);
    settle(10);
    chk("R7 chip start", n_start, 5);
    chk("R7 chip kind", {30'b0, last_kind}, 32'h3);
    chk("R7 chip addr", {10'b0, last_addr}, 32'h0);

    // R4 reset mid-sequence
    cur_req = "R4";
    clr0 = n_clr;
    wr(22'h000555, 16'h00AA); wr(22'h000555, 16'h00F0);
    wr(22'h000555, 16'h00A0); wr(22'h000010, 16'h0000);
    settle(4);
    chk("R4 mid-sequence clear", n_clr, clr0 + 1);
    chk("R4 sequence dropped", n_start, 5);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule